// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Manager

This block takes a DRAM into its low-power retention state and brings it back out. When a sleep request arrives it first makes sure no row is left owing a refresh: if the distributed refresh logic reports outstanding rows, it issues that many CAS-before-RAS refresh cycles as a catch-up burst. It then drops CAS, drops RAS a programmable number of cycles later with WE held high, and keeps RAS low. That long CAS-before-RAS pulse places the memory in self refresh.

The manager refuses to release RAS before the minimum self-refresh hold has run out. A RAS low time shorter than that minimum would leave the device in a forbidden transitional state. A wake request that arrives early is remembered and acted on once the minimum has passed. On exit it raises RAS and CAS together and holds a long self-refresh precharge. It then refreshes every row with back-to-back CAS-before-RAS cycles, and only after the last of these does it pulse `wake_done` and hand the strobes back. Each departure from self refresh is therefore followed by a complete refresh, so the next entry is always legal.

While it owns the bus, the manager drives RAS, CAS and WE and raises `bus_own`. The surrounding controller muxes these strobes onto the memory pins. All timing is counted in clock cycles through parameters.

Top module: `dram_selfrefresh_mgr`

## Requirements
- R1: After reset, and whenever `bus_own` is 0, `ras_n`, `cas_n` and `we_n` are 1 and `sleep_ack` and `wake_done` are 0. A `wake_req` that arrives while the block is idle is ignored and starts nothing.
- R2: A `sleep_req` seen while idle with `rows_pending` = P issues exactly P refresh cycles before entry. When P = 0, entry starts at once with no refresh cycles.
- R3: Every refresh cycle and the entry use CAS-before-RAS order. `cas_n` is low for exactly CSR_CYC cycles with `ras_n` high before `ras_n` falls. A refresh cycle holds `ras_n` low for exactly RAS_CYC cycles. `we_n` stays 1 throughout.
- R4: `sleep_ack` is 1 exactly while RAS is held low in self refresh, and `ras_n` and `cas_n` are both 0 whenever it is 1.
- R5: The self-refresh RAS low time is at least SR_MIN_CYC cycles. It equals max(SR_MIN_CYC, k+1), where k is the number of cycles between the first cycle with `sleep_ack` = 1 and the cycle in which a one-cycle `wake_req` pulse is driven. A pulse given during the catch-up burst or the entry delay also counts, and in that case the low time is exactly SR_MIN_CYC.
- R6: On exit, `ras_n` and `cas_n` rise in the same cycle, and `ras_n` then stays high for exactly RPS_CYC + CSR_CYC cycles before the next RAS fall.
- R7: After exit, exactly ROWS refresh cycles are issued. `wake_done` is then 1 for exactly one cycle, and `bus_own` is 0 in the cycle after that.
- R8: Once a sleep sequence has started, changes on `sleep_req` have no effect. Only `wake_req` ends self refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Request to enter self refresh (level, sampled only while idle) |
| rows_pending | input | $clog2(ROWS+1) | Rows still owing a refresh, from the distributed refresh logic |
| wake_req | input | 1 | Request to leave self refresh (a pulse is enough) |
| sleep_ack | output | 1 | High while the memory is held in self refresh |
| wake_done | output | 1 | One-cycle pulse when the exit refresh burst has completed |
| bus_own | output | 1 | High while this block owns the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |

## Verification
The bench runs sleep and wake episodes in which the pending-row count and the wake moment are drawn at random, and adds directed cases: zero and full pending counts, a wake pulse given during the catch-up burst, and a wake given exactly at the minimum hold. Varying the pending count separates a correct catch-up length from an off-by-one or a skipped burst. Moving the wake moment before, at and after the minimum hold separates correct pending of an early wake from both a premature RAS release and a lost wake request. A monitor measures every RAS pulse and precharge gap, so the CAS lead, the refresh pulse shape, the exit precharge length and the exit burst count are each compared against values computed from the parameters.

// File: rtl/srm_pkg.sv
package srm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CATCH, ST_ENTER, ST_SELF, ST_EXITP, ST_BURST, ST_WDONE
  } srm_state_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_CAS, PH_RAS, PH_PRE
  } cbr_phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/srm_timer.sv
module srm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/srm_cbr_burst.sv
module srm_cbr_burst
  import srm_pkg::*;
#(
  parameter int RW      = 13,
  parameter int CSR_CYC = 1,
  parameter int RAS_CYC = 8,
  parameter int RP_CYC  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] nrows,
  output logic          busy,
  output logic          done,
  output logic          ras_n,
  output logic          cas_n
);
  localparam int ETW = $clog2(max3(CSR_CYC, RAS_CYC, RP_CYC) + 1);

  cbr_phase_e     ph, ph_nxt;
  logic [RW-1:0]  rows_left;
  logic           tload, tzero;
  logic [ETW-1:0] tval;

  srm_timer #(.W(ETW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tload), .val(tval), .zero(tzero)
  );

  always_comb begin
    ph_nxt = ph;
    tload  = 1'b0;
    tval   = '0;
    done   = 1'b0;
    unique case (ph)
      PH_IDLE: if (start) begin
        ph_nxt = PH_CAS; tload = 1'b1; tval = ETW'(CSR_CYC - 1);
      end
      PH_CAS: if (tzero) begin
        ph_nxt = PH_RAS; tload = 1'b1; tval = ETW'(RAS_CYC - 1);
      end
      PH_RAS: if (tzero) begin
        ph_nxt = PH_PRE; tload = 1'b1; tval = ETW'(RP_CYC - 1);
      end
      PH_PRE: if (tzero) begin
        if (rows_left == RW'(1)) begin
          done   = 1'b1;
          ph_nxt = PH_IDLE;
        end else begin
          ph_nxt = PH_CAS; tload = 1'b1; tval = ETW'(CSR_CYC - 1);
        end
      end
      default: ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      rows_left <= '0;
    end else begin
      ph <= ph_nxt;
      if (ph == PH_IDLE && start)    rows_left <= nrows;
      else if (ph == PH_PRE && tzero) rows_left <= rows_left - 1'b1;
    end
  end

  assign busy  = (ph != PH_IDLE);
  assign ras_n = (ph != PH_RAS);
  assign cas_n = !(ph == PH_CAS || ph == PH_RAS);

  AST_ENG_START_OK: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!busy && nrows != '0)); // R2
  AST_ENG_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n))); // R3
endmodule

// File: rtl/dram_selfrefresh_mgr.sv
module dram_selfrefresh_mgr
  import srm_pkg::*;
#(
  parameter int ROWS       = 4096,
  parameter int CSR_CYC    = 1,
  parameter int RAS_CYC    = 8,
  parameter int RP_CYC     = 7,
  parameter int SR_MIN_CYC = 12500,
  parameter int RPS_CYC    = 14,
  localparam int RW        = $clog2(ROWS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_req,
  input  logic [RW-1:0] rows_pending,
  input  logic          wake_req,
  output logic          sleep_ack,
  output logic          wake_done,
  output logic          bus_own,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n
);
  localparam int TW = $clog2(max3(SR_MIN_CYC, RPS_CYC, CSR_CYC) + 1);

  srm_state_e    state, nxt;
  logic          tload, tzero;
  logic [TW-1:0] tval;
  logic          eng_start, eng_busy, eng_done, eng_ras_n, eng_cas_n;
  logic [RW-1:0] eng_rows;
  logic          wake_pend, sleeping;
  logic [TW-1:0] sr_len;

  srm_timer #(.W(TW)) u_hold_tmr (
    .clk(clk), .rst_n(rst_n), .load(tload), .val(tval), .zero(tzero)
  );

  srm_cbr_burst #(
    .RW(RW), .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
  ) u_burst (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .nrows(eng_rows),
    .busy(eng_busy), .done(eng_done), .ras_n(eng_ras_n), .cas_n(eng_cas_n)
  );

  always_comb begin
    nxt       = state;
    tload     = 1'b0;
    tval      = '0;
    eng_start = 1'b0;
    eng_rows  = RW'(ROWS);
    unique case (state)
      ST_IDLE: if (sleep_req) begin
        if (rows_pending != '0) begin
          nxt = ST_CATCH; eng_start = 1'b1; eng_rows = rows_pending;
        end else begin
          nxt = ST_ENTER; tload = 1'b1; tval = TW'(CSR_CYC - 1);
        end
      end
      ST_CATCH: if (eng_done) begin
        nxt = ST_ENTER; tload = 1'b1; tval = TW'(CSR_CYC - 1);
      end
      ST_ENTER: if (tzero) begin
        nxt = ST_SELF; tload = 1'b1; tval = TW'(SR_MIN_CYC - 1);
      end
      ST_SELF: if (tzero && (wake_pend || wake_req)) begin
        nxt = ST_EXITP; tload = 1'b1; tval = TW'(RPS_CYC - 1);
      end
      ST_EXITP: if (tzero) begin
        nxt = ST_BURST; eng_start = 1'b1;
      end
      ST_BURST: if (eng_done) nxt = ST_WDONE;
      ST_WDONE: nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign sleeping = (state == ST_CATCH) || (state == ST_ENTER) || (state == ST_SELF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wake_pend <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_SELF && nxt != ST_SELF) wake_pend <= 1'b0;
      else if (sleeping && wake_req)          wake_pend <= 1'b1;
    end
  end

  always_comb begin
    unique case (state)
      ST_CATCH, ST_BURST: begin ras_n = eng_ras_n; cas_n = eng_cas_n; end
      ST_ENTER:           begin ras_n = 1'b1;      cas_n = 1'b0;      end
      ST_SELF:            begin ras_n = 1'b0;      cas_n = 1'b0;      end
      default:            begin ras_n = 1'b1;      cas_n = 1'b1;      end
    endcase
  end

  assign we_n      = 1'b1;
  assign sleep_ack = (state == ST_SELF);
  assign wake_done = (state == ST_WDONE);
  assign bus_own   = (state != ST_IDLE);

  // Length of the current self-refresh hold, kept for the hold check.
  always_ff @(posedge clk) begin
    if (!rst_n)                      sr_len <= '0;
    else if (!sleep_ack)             sr_len <= '0;
    else if (sr_len != {TW{1'b1}})   sr_len <= sr_len + 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |-> (ras_n && cas_n && !sleep_ack && !wake_done)); // R1
  AST_ENTRY_CBR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_ack) |-> ($past(!cas_n) && $past(ras_n))); // R3
  AST_ACK_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ack |-> (!ras_n && !cas_n)); // R4
  AST_SR_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_ack) |-> (sr_len >= TW'(SR_MIN_CYC))); // R5
  AST_EXIT_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_ack) |-> (ras_n && cas_n)); // R6
  AST_BURST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BURST) |-> eng_busy); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> (!wake_done && !bus_own)); // R7
endmodule

// File: tb/dram_selfrefresh_mgr_bench.sv
module dram_selfrefresh_mgr_bench;
  localparam int ROWS = 6, CSR_CYC = 2, RAS_CYC = 3, RP_CYC = 2;
  localparam int SR_MIN_CYC = 40, RPS_CYC = 5;
  localparam int RW = $clog2(ROWS + 1);

  logic clk = 1'b0, rst_n = 1'b0, sleep_req = 1'b0, wake_req = 1'b0;
  logic [RW-1:0] rows_pending = '0;
  logic sleep_ack, wake_done, bus_own, ras_n, cas_n, we_n;

  always #4 clk = ~clk;

  dram_selfrefresh_mgr #(
    .ROWS(ROWS), .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC),
    .SR_MIN_CYC(SR_MIN_CYC), .RPS_CYC(RPS_CYC)
  ) u_dram_selfrefresh_mgr (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .rows_pending(rows_pending),
    .wake_req(wake_req), .sleep_ack(sleep_ack), .wake_done(wake_done),
    .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_sr_width(input int off, input bit early);
    if (early) return SR_MIN_CYC;
    return (off + 1 > SR_MIN_CYC) ? off + 1 : SR_MIN_CYC;
  endfunction

  // Strobe monitor
  int high_run = 0, low_run = 0, lead = 0, cbr_cnt = 0, bad_shape = 0;
  int sr_width = 0, sr_lead = 0, exit_pre = 0, exit_cas_bad = 0, we_bad = 0, ack_bad = 0;
  bit after_sr = 1'b0, prev_ras = 1'b1, prev_ack = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (we_n !== 1'b1) we_bad++;
      if (sleep_ack && (ras_n || cas_n)) ack_bad++;
      if (prev_ras && !ras_n) begin
        if (sleep_ack) sr_lead = lead;
        else if (lead != CSR_CYC) bad_shape++;
        if (after_sr) begin exit_pre = high_run; after_sr = 1'b0; end
        low_run = 1; high_run = 0;
      end else if (!prev_ras && ras_n) begin
        if (prev_ack) begin
          sr_width = low_run; after_sr = 1'b1;
          if (cas_n !== 1'b1) exit_cas_bad++;
        end else begin
          cbr_cnt++;
          if (low_run != RAS_CYC) bad_shape++;
        end
        high_run = 1; low_run = 0;
      end else if (!ras_n) low_run++;
      else high_run++;
      if (ras_n && !cas_n) lead++;
      else if (cas_n) lead = 0;
      prev_ras = ras_n;
      prev_ack = sleep_ack;
    end
  end

  task automatic episode(input int p, input int off, input bit early);
    int n;
    bit seen;
    @(negedge clk);
    rows_pending = RW'(p);
    cbr_cnt = 0; bad_shape = 0; exit_cas_bad = 0;
    sleep_req = 1'b1;
    if (early) begin
      @(negedge clk); wake_req = 1'b1;
      @(negedge clk); wake_req = 1'b0;
    end
    seen = 1'b0;
    for (n = 0; n < 4000 && !seen; n++) begin
      @(negedge clk); #1;
      if (sleep_ack) seen = 1'b1;
    end
    check(seen, "R4 sleep_ack reached", int'(seen), 1);
    sleep_req = 1'b0;
    check(cbr_cnt == p, "R2 catch-up refresh count", cbr_cnt, p);
    check(sr_lead == CSR_CYC, "R3 entry CAS lead", sr_lead, CSR_CYC);
    cbr_cnt = 0;
    if (!early) begin
      for (int k = 0; k < off; k++) begin
        @(negedge clk);
        if (k == 1) sleep_req = 1'b1;
        if (k == 2) sleep_req = 1'b0;
      end
      #1;
      check(sleep_ack == 1'b1, "R8 sleep_req toggle ignored in self refresh", int'(sleep_ack), 1);
      wake_req = 1'b1;
      @(negedge clk); wake_req = 1'b0;
    end
    seen = 1'b0;
    for (n = 0; n < 4000 && !seen; n++) begin
      @(negedge clk); #1;
      if (wake_done) seen = 1'b1;
    end
    check(seen, "R7 wake_done reached", int'(seen), 1);
    check(cbr_cnt == ROWS, "R7 exit burst count", cbr_cnt, ROWS);
    check(sr_width == exp_sr_width(off, early), "R5 self-refresh RAS low width",
          sr_width, exp_sr_width(off, early));
    check(exit_pre == RPS_CYC + CSR_CYC, "R6 exit precharge", exit_pre, RPS_CYC + CSR_CYC);
    check(exit_cas_bad == 0, "R6 CAS rises with RAS", exit_cas_bad, 0);
    check(bad_shape == 0, "R3 refresh cycle shape", bad_shape, 0);
    @(negedge clk); #1;
    check(!wake_done && !bus_own, "R7 single wake_done then release",
          int'(wake_done) + int'(bus_own), 0);
    check(ras_n && cas_n, "R1 strobes idle after release", int'(ras_n && cas_n), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R7 run did not end actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(negedge clk);
    #1;
    check(ras_n && cas_n && we_n && !bus_own && !sleep_ack && !wake_done,
          "R1 reset state", int'(bus_own), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    wake_req = 1'b1;
    @(negedge clk); wake_req = 1'b0;
    repeat (10) @(negedge clk);
    #1;
    check(!bus_own && ras_n && cas_n && !sleep_ack, "R1 idle wake ignored", int'(bus_own), 0);

    episode(0, 3, 1'b0);                    // R2 no catch-up, R5 early wake
    episode(ROWS, SR_MIN_CYC - 1, 1'b0);    // R5 wake at the minimum
    episode(ROWS, 0, 1'b1);                 // R5 wake pended during catch-up
    episode(1, SR_MIN_CYC + 15, 1'b0);      // R5 late wake
    for (int i = 0; i < 10; i++) begin
      episode(int'($urandom % (ROWS + 1)), 1 + int'($urandom % (SR_MIN_CYC + 20)), 1'b0);
    end
    check(we_bad == 0, "R3 we_n held high", we_bad, 0);
    check(ack_bad == 0, "R4 sleep_ack only with strobes low", ack_bad, 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule